// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of an x16 NOR-style flash controller. Each clock it may take one qualified write, an address plus a data word, and it matches that write against the multi-cycle command sequences the memory accepts. A full sequence opens with two unlock writes, followed by a command write and, for some commands, further unlock or operand writes. When a sequence completes, the block raises a one-cycle strobe. For program it carries the captured program address and data. For erase, suspend and resume it carries the target sector or bank address.

Besides the strobes, the block tracks the mode the memory is in: array read, identification (autoselect), CFI query, unlock bypass, or erase suspended. A short-form path is used in unlock-bypass mode, where program and erase need only two writes. Suspend and resume are accepted only in their proper context. That context comes from an external embedded-busy input and from the block's own record of which operation it last started.

The array, embedded program/erase timing, status polling and burst reads are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, mode is 0 (array read), all strobes are low and bank is 0. Mode codes are: 0 read, 1 autoselect, 2 CFI, 3 bypass, 4 erase-suspend.
- R2: An unlock write compares only address bits [11:0] and data bits [7:0]. The first unlock is AAh at AAAh and the second is 55h at 555h. Higher address and data bits have no effect on matching.
- R3: The writes unlock, unlock, A0h at AAAh, then any address/data pulse prog_stb for one cycle after the fourth write, with cmd_addr and cmd_data equal to that write's address and data.
- R4: The writes unlock, unlock, 80h at AAAh, unlock, unlock, then a final write select the erase. The final write is 10h at AAAh for chip erase (chip_erase_stb) or 30h at any address for sector erase (sector_erase_stb, with cmd_addr set to that address). Erase setup is ignored while suspended.
- R5: A write that does not match the expected next step of a sequence ends that sequence without any strobe. The decoder then waits for a fresh sequence.
- R6: The writes unlock, unlock, 90h at AAAh set mode 1 and capture bank = address bits [18:17]. A single F0h write at any address returns the mode to 0, or to 4 while suspended. Autoselect entry is ignored while embedded_busy is high or while suspended.
- R7: A single 98h write whose address bits [7:0] are 55h sets mode 2 when embedded_busy is low. It is ignored otherwise, and F0h returns to read.
- R8: B0h pulses suspend_stb and enters suspend (mode 4 from read) only if embedded_busy is high, the last erase started was a sector erase, and the decoder is not already suspended. 30h outside a sequence pulses resume_stb only while suspended. Both capture cmd_addr and bank from the write.
- R9: The writes unlock, unlock, 20h at AAAh set mode 3 (bypass). This is ignored while embedded_busy is high or while suspended.
- R10: In bypass, the write A0h followed by one address/data write pulses prog_stb. The write 80h followed by 10h or 30h pulses chip_erase_stb or sector_erase_stb.
- R11: In bypass, 90h followed by 00h returns the mode to 0, and a single F0h write has no effect.
- R12: Strobes last one cycle, at most one is high at a time, and none rises without a qualified write on the previous edge. Idle cycles between writes neither advance nor break a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Qualifies one write this cycle |
| wr_addr | input | 19 | Write word address |
| wr_data | input | 16 | Write data |
| embedded_busy | input | 1 | An embedded program or erase is running |
| prog_stb | output | 1 | Program command accepted |
| chip_erase_stb | output | 1 | Chip erase accepted |
| sector_erase_stb | output | 1 | Sector erase accepted |
| suspend_stb | output | 1 | Suspend accepted |
| resume_stb | output | 1 | Resume accepted |
| cmd_addr | output | 19 | Address captured with the current strobe |
| cmd_data | output | 16 | Data captured with the current strobe |
| mode | output | 3 | Current mode code |
| bank | output | 2 | Bank captured by autoselect, suspend or resume |

## Verification
The assertions watch the properties that hold at every edge. Strobes stay mutually exclusive and never rise without a write. Program and erase strobes never repeat on consecutive cycles. A suspend strobe always follows a busy cycle, a resume only follows erase-suspend mode, and sequencer state and mode hold still through idle cycles. Whether a given write order yields the right command, the right captured address, bank and data, or no command at all can only be shown by the bench's scenarios. These include the masked-bit sweep of unlock writes, the aborted prefixes, the context gating of suspend, autoselect and bypass entry, and the bypass short forms.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CODE_W   = 8;
  localparam int UNLOCK_W = 12;

  localparam logic [CODE_W-1:0] C_UNLK1   = 8'hAA;
  localparam logic [CODE_W-1:0] C_UNLK2   = 8'h55;
  localparam logic [CODE_W-1:0] C_IDENT   = 8'h90;
  localparam logic [CODE_W-1:0] C_PROG    = 8'hA0;
  localparam logic [CODE_W-1:0] C_ERSETUP = 8'h80;
  localparam logic [CODE_W-1:0] C_BPENTER = 8'h20;
  localparam logic [CODE_W-1:0] C_CHIP    = 8'h10;
  localparam logic [CODE_W-1:0] C_SECT    = 8'h30;
  localparam logic [CODE_W-1:0] C_RESET   = 8'hF0;
  localparam logic [CODE_W-1:0] C_QUERY   = 8'h98;
  localparam logic [CODE_W-1:0] C_SUSP    = 8'hB0;
  localparam logic [CODE_W-1:0] C_RESUME  = 8'h30;
  localparam logic [CODE_W-1:0] C_BPEXIT1 = 8'h90;
  localparam logic [CODE_W-1:0] C_BPEXIT2 = 8'h00;

  localparam logic [UNLOCK_W-1:0] A_UNLK1 = 12'hAAA;
  localparam logic [UNLOCK_W-1:0] A_UNLK2 = 12'h555;
  localparam logic [7:0]          A_QUERY = 8'h55;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_CFI     = 3'd2,
    MODE_BYPASS  = 3'd3,
    MODE_ESUSP   = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UL1, SQ_UL2, SQ_PROG, SQ_ER1, SQ_ER2, SQ_ER3,
    SQ_BP_PROG, SQ_BP_ER, SQ_BP_EXIT
  } seq_e;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
    logic reset;
    logic autosel;
    logic cfi;
    logic bp_enter;
    logic bp_exit;
  } cmd_ev_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
#(
  parameter int UW = UNLOCK_W,
  parameter int CW = CODE_W
) (
  input  logic [UW-1:0] addr_lo,
  input  logic [CW-1:0] data_lo,
  output logic          at_first,
  output logic          at_second,
  output logic          at_query,
  output logic [CW-1:0] code
);
  // Only the low address bits take part in any address compare.
  assign at_first  = (addr_lo == UW'(A_UNLK1));
  assign at_second = (addr_lo == UW'(A_UNLK2));
  assign at_query  = (addr_lo[7:0] == A_QUERY);
  assign code      = data_lo;
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              at_first,
  input  logic              at_second,
  input  logic              at_query,
  input  logic [CODE_W-1:0] code,
  input  logic              in_bypass,
  input  logic              busy,
  input  logic              susp,
  input  logic              sector_run,
  output cmd_ev_t           ev
);
  seq_e st_q, st_d;
  logic can_susp;
  logic is_unlk1, is_unlk2;

  assign can_susp = busy && sector_run && !susp;
  assign is_unlk1 = (code == C_UNLK1) && at_first;
  assign is_unlk2 = (code == C_UNLK2) && at_second;

  always_comb begin
    st_d = st_q;
    ev   = '0;
    if (wr_valid) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE: begin
          if (in_bypass) begin
            if (code == C_PROG)                  st_d = SQ_BP_PROG;
            else if (code == C_ERSETUP && !susp) st_d = SQ_BP_ER;
            else if (code == C_BPEXIT1)          st_d = SQ_BP_EXIT;
            else if (code == C_SUSP)             ev.susp = can_susp;
            else if (code == C_RESUME)           ev.resume = susp;
          end else begin
            if (is_unlk1)                        st_d = SQ_UL1;
            else if (code == C_RESET)            ev.reset = 1'b1;
            else if (code == C_QUERY && at_query) ev.cfi = !busy;
            else if (code == C_SUSP)             ev.susp = can_susp;
            else if (code == C_RESUME)           ev.resume = susp;
          end
        end
        SQ_UL1: if (is_unlk2) st_d = SQ_UL2;
        SQ_UL2: begin
          if (at_first) begin
            if (code == C_PROG)                     st_d = SQ_PROG;
            else if (code == C_ERSETUP && !susp)    st_d = SQ_ER1;
            else if (code == C_IDENT)               ev.autosel = !busy && !susp;
            else if (code == C_BPENTER)             ev.bp_enter = !busy && !susp;
          end
        end
        SQ_PROG:    ev.prog = 1'b1;
        SQ_ER1:     if (is_unlk1) st_d = SQ_ER2;
        SQ_ER2:     if (is_unlk2) st_d = SQ_ER3;
        SQ_ER3: begin
          if (code == C_CHIP && at_first) ev.chip = 1'b1;
          else if (code == C_SECT)        ev.sect = 1'b1;
        end
        SQ_BP_PROG: ev.prog = 1'b1;
        SQ_BP_ER: begin
          if (code == C_CHIP)      ev.chip = 1'b1;
          else if (code == C_SECT) ev.sect = 1'b1;
        end
        SQ_BP_EXIT: ev.bp_exit = (code == C_BPEXIT2);
        default:    st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_d;
  end

  // R12: sequencer state does not move on cycles without a write
  p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(st_q));
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_ev_t           ev,
  input  logic [BANK_W-1:0] bank_in,
  output mode_e             mode_o,
  output logic              susp,
  output logic              sector_run,
  output logic              in_bypass,
  output logic [BANK_W-1:0] bank_o
);
  mode_e base_q;
  logic  susp_q, srun_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= MODE_READ;
      susp_q <= 1'b0;
      srun_q <= 1'b0;
      bank_q <= '0;
    end else begin
      if (ev.autosel)                 base_q <= MODE_AUTOSEL;
      else if (ev.cfi)                base_q <= MODE_CFI;
      else if (ev.bp_enter)           base_q <= MODE_BYPASS;
      else if (ev.bp_exit || ev.reset) base_q <= MODE_READ;

      if (ev.susp)        susp_q <= 1'b1;
      else if (ev.resume) susp_q <= 1'b0;

      if (ev.sect)                             srun_q <= 1'b1;
      else if (ev.chip || (ev.prog && !susp_q)) srun_q <= 1'b0;

      if (ev.autosel || ev.susp || ev.resume) bank_q <= bank_in;
    end
  end

  assign mode_o     = (base_q == MODE_READ && susp_q) ? MODE_ESUSP : base_q;
  assign susp       = susp_q;
  assign sector_run = srun_q;
  assign in_bypass  = (base_q == MODE_BYPASS);
  assign bank_o     = bank_q;

  // R8: the sequencer only offers a resume while suspended
  p_resume_ctx_r8: assert property (@(posedge clk) disable iff (rst)
    ev.resume |-> susp_q);
  // R8: a suspend is never offered twice without a resume between
  p_susp_once_r8: assert property (@(posedge clk) disable iff (rst)
    ev.susp |-> !susp_q);
endmodule

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int NSTB   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTB-1:0]   stb_d,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NSTB-1:0]   stb_q,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int PE_W = 3; // program, chip erase, sector erase in the top bits

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q    <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      stb_q <= stb_d;
      if (|stb_d) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
    end
  end

  // R12: at most one strobe at a time
  p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));
  // R3: program/erase strobes need at least two writes, never back to back
  p_pe_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (|stb_q[NSTB-1 -: PE_W]) |=> !(|stb_q[NSTB-1 -: PE_W]));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              embedded_busy,
  output logic              prog_stb,
  output logic              chip_erase_stb,
  output logic              sector_erase_stb,
  output logic              suspend_stb,
  output logic              resume_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [2:0]        mode,
  output logic [BANK_W-1:0] bank
);
  localparam int NSTB = 5;

  logic              at_first, at_second, at_query;
  logic [CODE_W-1:0] code;
  cmd_ev_t           ev;
  mode_e             mode_w;
  logic              susp, sector_run, in_bypass;
  logic [NSTB-1:0]   stb_d, stb_q;

  fcd_match #(.UW(UNLOCK_W), .CW(CODE_W)) u_match (
    .addr_lo  (wr_addr[UNLOCK_W-1:0]),
    .data_lo  (wr_data[CODE_W-1:0]),
    .at_first (at_first),
    .at_second(at_second),
    .at_query (at_query),
    .code     (code)
  );

  fcd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .at_first  (at_first),
    .at_second (at_second),
    .at_query  (at_query),
    .code      (code),
    .in_bypass (in_bypass),
    .busy      (embedded_busy),
    .susp      (susp),
    .sector_run(sector_run),
    .ev        (ev)
  );

  fcd_mode #(.BANK_W(BANK_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .bank_in   (wr_addr[ADDR_W-1 -: BANK_W]),
    .mode_o    (mode_w),
    .susp      (susp),
    .sector_run(sector_run),
    .in_bypass (in_bypass),
    .bank_o    (bank)
  );

  assign stb_d = {ev.prog, ev.chip, ev.sect, ev.susp, ev.resume};

  fcd_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTB(NSTB)) u_stb (
    .clk     (clk),
    .rst     (rst),
    .stb_d   (stb_d),
    .addr    (wr_addr),
    .data    (wr_data),
    .stb_q   (stb_q),
    .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  assign {prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb} = stb_q;
  assign mode = mode_w;

  // R12: no strobe without a write on the previous edge
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_valid) |-> (stb_q == '0));
  // R12: mode holds through idle cycles
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_valid) |-> $stable(mode));
  // R8: suspend only while an embedded operation runs
  p_susp_busy_r8: assert property (@(posedge clk) disable iff (rst)
    suspend_stb |-> $past(embedded_busy));
  // R8: resume only out of the suspended state
  p_resume_mode_r8: assert property (@(posedge clk) disable iff (rst)
    resume_stb |-> ($past(mode) == 3'd4 || $past(susp)));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        embedded_busy = 1'b0;
  logic        prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb;
  logic [18:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [2:0]  mode;
  logic [1:0]  bank;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [4:0] S_NONE = 5'b00000, S_PROG = 5'b10000, S_CHIP = 5'b01000,
                         S_SECT = 5'b00100, S_SUSP = 5'b00010, S_RES  = 5'b00001;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .embedded_busy(embedded_busy), .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb),
    .sector_erase_stb(sector_erase_stb), .suspend_stb(suspend_stb), .resume_stb(resume_stb),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mode(mode), .bank(bank)
  );

  task automatic check(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one write, then return at the negedge just after the sampling edge
  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic stb(input string req, input logic [4:0] exp);
    check(req, {prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb}, exp);
  endtask

  task automatic unlock(input logic [18:0] hi, input logic [15:0] dhi);
    wr(hi | 19'hAAA, dhi | 16'h00AA);
    wr(hi | 19'h555, dhi | 16'h0055);
  endtask

  task automatic cmd3(input logic [15:0] c);
    unlock('0, '0);
    wr(19'hAAA, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 bank", bank, 0);
    stb("R1 strobes", S_NONE);

    // R2/R3: sweep of masked high address/data bits on the unlock writes
    for (int i = 0; i < 16; i++) begin
      logic [18:0] hi, pa;
      logic [15:0] dhi, pd;
      hi  = 19'(i * 4096 + i * 32768);
      dhi = 16'(i * 256 + i * 4096);
      pa  = 19'((i * 24593 + 77) % 524288);
      pd  = 16'(i * 4111 + 3);
      unlock(hi, dhi);
      wr(hi | 19'hAAA, dhi | 16'h00A0);
      stb("R2 no strobe before operand", S_NONE);
      wr(pa, pd);
      stb("R3 program strobe", S_PROG);
      check("R3 program address", cmd_addr, pa);
      check("R3 program data", cmd_data, pd);
      @(negedge clk);
      stb("R12 single cycle", S_NONE);
    end

    // R4 chip erase and sector erase
    cmd3(16'h0080); unlock('0, '0); wr(19'hAAA, 16'h0010);
    stb("R4 chip erase", S_CHIP);
    cmd3(16'h0080); unlock('0, '0); wr(19'h5A800, 16'h0030);
    stb("R4 sector erase", S_SECT);
    check("R4 sector address", cmd_addr, 19'h5A800);
    @(negedge clk);
    stb("R12 erase single cycle", S_NONE);

    // R5 aborts
    wr(19'hAAA, 16'h00AA); wr(19'h554, 16'h0055); wr(19'hAAA, 16'h00A0);
    wr(19'h01234, 16'h5678);
    stb("R5 bad second unlock", S_NONE);
    cmd3(16'h0080); wr(19'hAAA, 16'h00AA); wr(19'h555, 16'h0056); wr(19'hAAA, 16'h0010);
    stb("R5 bad erase unlock", S_NONE);
    cmd3(16'h0077); wr(19'h00100, 16'h0030);
    stb("R5 unknown code", S_NONE);
    check("R5 mode after aborts", mode, 0);
    cmd3(16'h00A0); wr(19'h00042, 16'h0042);
    stb("R5 recovery", S_PROG);

    // R6 autoselect
    unlock('0, '0); wr(19'h60AAA, 16'h0090);
    check("R6 autoselect mode", mode, 1);
    check("R6 bank capture", bank, 3);
    wr(19'h12345, 16'h00F0);
    check("R6 reset to read", mode, 0);
    embedded_busy = 1'b1;
    cmd3(16'h0090);
    check("R6 ignored while busy", mode, 0);
    embedded_busy = 1'b0;

    // R7 CFI
    wr(19'h00055, 16'h0098);
    check("R7 CFI entry", mode, 2);
    wr(19'h00000, 16'h00F0);
    check("R7 CFI exit", mode, 0);
    wr(19'h01234, 16'h0098);
    check("R7 wrong address", mode, 0);
    embedded_busy = 1'b1;
    wr(19'h00055, 16'h0098);
    check("R7 ignored while busy", mode, 0);

    // R8 suspend/resume (busy, last erase was a sector erase)
    embedded_busy = 1'b0;
    cmd3(16'h0080); unlock('0, '0); wr(19'h20000, 16'h0030);
    wr(19'h40000, 16'h00B0);
    stb("R8 suspend while idle", S_NONE);
    embedded_busy = 1'b1;
    wr(19'h40000, 16'h0030);
    stb("R8 resume when not suspended", S_NONE);
    wr(19'h40000, 16'h00B0);
    stb("R8 suspend strobe", S_SUSP);
    check("R8 suspend address", cmd_addr, 19'h40000);
    check("R8 suspend mode", mode, 4);
    check("R8 suspend bank", bank, 2);
    wr(19'h40000, 16'h00B0);
    stb("R8 second suspend", S_NONE);
    cmd3(16'h0090);
    check("R6 ignored while suspended", mode, 4);
    cmd3(16'h0020);
    check("R9 ignored while suspended", mode, 4);
    cmd3(16'h0080); unlock('0, '0); wr(19'hAAA, 16'h0010);
    stb("R4 erase ignored while suspended", S_NONE);
    wr(19'h00000, 16'h00F0);
    check("R6 reset keeps suspend", mode, 4);
    wr(19'h60000, 16'h0030);
    stb("R8 resume strobe", S_RES);
    check("R8 resume mode", mode, 0);
    check("R8 resume bank", bank, 3);
    embedded_busy = 1'b0;
    cmd3(16'h0080); unlock('0, '0); wr(19'hAAA, 16'h0010);
    embedded_busy = 1'b1;
    wr(19'h00000, 16'h00B0);
    stb("R8 no suspend of chip erase", S_NONE);

    // R9 bypass entry gating
    cmd3(16'h0020);
    check("R9 ignored while busy", mode, 0);
    embedded_busy = 1'b0;
    cmd3(16'h0020);
    check("R9 bypass entry", mode, 3);

    // R10 bypass short forms
    wr(19'h00000, 16'h00A0); wr(19'h3C0DE, 16'hBEEF);
    stb("R10 bypass program", S_PROG);
    check("R10 bypass program address", cmd_addr, 19'h3C0DE);
    check("R10 bypass program data", cmd_data, 16'hBEEF);
    wr(19'h00000, 16'h0080); wr(19'h11000, 16'h0030);
    stb("R10 bypass sector erase", S_SECT);
    check("R10 bypass sector address", cmd_addr, 19'h11000);
    wr(19'h00000, 16'h0080); wr(19'h00000, 16'h0010);
    stb("R10 bypass chip erase", S_CHIP);

    // R11 bypass exit
    wr(19'h00000, 16'h00F0);
    check("R11 F0 ignored in bypass", mode, 3);
    stb("R11 F0 no strobe", S_NONE);
    wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0001);
    check("R11 wrong exit data", mode, 3);
    wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0000);
    check("R11 bypass exit", mode, 0);
    wr(19'h00000, 16'h00A0); wr(19'h00010, 16'h0010);
    stb("R11 short program gone", S_NONE);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule